// File: doc/BRIEF.md
# Glitchless Two-Source Clock Multiplexer

The block picks one of two unrelated input clocks and passes it to a single output clock. Changing the select input never produces a shortened high or low phase at the output. Each source has an enable. The enable is resynchronized on the falling edges of its own clock, and it is only requested while the other source's enable is clear. At most one source can therefore reach the output at any time.

A change of select goes through two phases. In the release phase, the old source keeps driving the output for a couple of its own falling edges and then is gated off. In the acquire phase, the new source's enable ripples through its own synchronizer, and the output restarts on the next rising edge of the new clock. If either clock has stopped in its low state, the output simply waits at low until that clock runs again.

Top module: `glitchless_clk_mux`

## Requirements
- R1: While rst_ni is low the output is low and both enables are clear. After rst_ni rises, the first output pulse comes from the clock chosen by sel_i (0 picks clk0_i, 1 picks clk1_i). It begins on the rising edge that follows 2 to 3 falling edges of that clock counted from the reset release.
- R2: Every output high phase starts on a rising edge of an input clock and ends on the next falling edge of the same clock. Its width therefore equals that clock's high phase, and no runt pulse or glitch appears. An enable changes only while its own clock is low.
- R3: At most one source is enabled at any time. Once the handover to a source is complete, no pulse from the other source reaches the output.
- R4: After sel_i changes, the output keeps following the old clock for the pulses that end on its next 2 to 3 falling edges. After that the output is held low.
- R5: After the old source is released, the output stays low for 2 to 3 falling edges of the new clock. It then starts on the next rising edge of the new clock.
- R6: If the newly chosen clock is stopped low, the output goes low after the release phase and stays low indefinitely. When that clock starts running, the output resumes from it after 2 to 3 of its falling edges.
- R7: If the old clock is stopped low when sel_i changes, the output stays low with no pulse. The handover completes, glitch-free, once the old clock runs again.
- R8: R2 to R5 hold for equal input frequencies and for input frequencies that differ by up to a factor of ten, in either direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk0_i | input | 1 | Source clock 0 |
| clk1_i | input | 1 | Source clock 1 |
| sel_i | input | 1 | Source select, asynchronous; 0 picks clk0_i, 1 picks clk1_i |
| rst_ni | input | 1 | Asynchronous active-low reset; clears both enables |
| clk_o | output | 1 | Gated output clock |

## Verification
The bench times every output edge against the input clock edges. A design that let an enable change while its clock is high would show up as a pulse narrower than the source's high phase, or as an edge with no matching source edge.

Each handover is measured in falling edges on both sides. A missing or extra synchronizer stage moves the old-pulse count or the acquire gap outside the two-to-three window. A broken cross-coupling lets the deselected source pulse after the handover.

Two stopped-clock cases are covered: a dead target and a dead origin. A design that waited on the wrong domain would hang, or would pass a pulse while one of the clocks was frozen. Frequency ratios of one and ten, plus random ratios in between, exercise the spread between the two sides.

// File: rtl/gmux_pkg.sv
`timescale 1ns/100ps
package gmux_pkg;
  localparam int SRC_CNT  = 2;
  localparam int MIN_SYNC = 2;
  typedef logic [SRC_CNT-1:0] src_vec_t;
endpackage

// File: rtl/gmux_enable_sync.sv
`timescale 1ns/100ps
module gmux_enable_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_i,
  input  logic other_en_i,
  output logic en_o
);
  logic              req;
  logic [STAGES-1:0] chain_q;

  // request only while the other domain has let go
  assign req = want_i & ~other_en_i;

  // falling-edge chain: enable moves only while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], req};
  end

  assign en_o = chain_q[STAGES-1];

  always @(en_o) begin
    if (rst_ni === 1'b1) begin
      p_en_low_clk_r2: assert (clk_i == 1'b0)
        else $error("enable moved while its clock was high");
    end
  end

  p_grant_clear_r3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(en_o) |-> !other_en_i);
endmodule

// File: rtl/gmux_gate.sv
`timescale 1ns/100ps
module gmux_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);
  assign gclk_o = clk_i & en_i;
endmodule

// File: rtl/glitchless_clk_mux.sv
`timescale 1ns/100ps
module glitchless_clk_mux
  import gmux_pkg::*;
#(
  parameter int SYNC_STAGES = MIN_SYNC
) (
  input  logic clk0_i,
  input  logic clk1_i,
  input  logic sel_i,
  input  logic rst_ni,
  output logic clk_o
);
  src_vec_t clk_src;
  src_vec_t en;
  src_vec_t gated;

  assign clk_src = {clk1_i, clk0_i};

  for (genvar i = 0; i < SRC_CNT; i++) begin : g_src
    gmux_enable_sync #(
      .STAGES(SYNC_STAGES)
    ) u_sync (
      .clk_i      (clk_src[i]),
      .rst_ni     (rst_ni),
      .want_i     (sel_i == 1'(i)),
      .other_en_i (en[SRC_CNT-1-i]),
      .en_o       (en[i])
    );

    gmux_gate u_gate (
      .clk_i  (clk_src[i]),
      .en_i   (en[i]),
      .gclk_o (gated[i])
    );
  end

  assign clk_o = |gated;

  p_mutex_clk0_r3: assert property (@(negedge clk0_i) disable iff (!rst_ni)
    !(en[0] && en[1]));

  p_mutex_clk1_r3: assert property (@(negedge clk1_i) disable iff (!rst_ni)
    !(en[0] && en[1]));

  always_comb begin
    if (rst_ni && !en[0] && !en[1]) begin
      p_out_idle_r2: assert (!clk_o) else $error("output high with no source enabled");
    end
  end
endmodule

// File: tb/sim_glitchless_clk_mux.sv
`timescale 1ns/100ps
module sim_glitchless_clk_mux;
  logic tb_clk = 1'b0;
  always #10 tb_clk = ~tb_clk;

  logic clk0_i, clk1_i, sel_i, rst_ni;
  logic clk_o;

  glitchless_clk_mux u0 (
    .clk0_i (clk0_i),
    .clk1_i (clk1_i),
    .sel_i  (sel_i),
    .rst_ni (rst_ni),
    .clk_o  (clk_o)
  );

  int  hp [2] = '{5, 7};
  bit  run[2] = '{1'b1, 1'b1};
  real rise_t[2], fall_t[2];
  int  rise_hp[2];
  int  fall_cnt[2] = '{0, 0};
  int  vectors = 0, fails = 0;

  // edges at k+0.3 and k+0.7 ns never coincide with each other or tb_clk
  initial begin
    clk0_i = 1'b0;
    #0.3;
    forever begin
      if (run[0] || clk0_i) begin
        clk0_i = ~clk0_i;
        if (clk0_i) begin rise_t[0] = $realtime; rise_hp[0] = hp[0]; end
        else begin fall_t[0] = $realtime; fall_cnt[0]++; end
      end
      #(hp[0]);
    end
  end

  initial begin
    clk1_i = 1'b0;
    #0.7;
    forever begin
      if (run[1] || clk1_i) begin
        clk1_i = ~clk1_i;
        if (clk1_i) begin rise_t[1] = $realtime; rise_hp[1] = hp[1]; end
        else begin fall_t[1] = $realtime; fall_cnt[1]++; end
      end
      #(hp[1]);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0.1f expected %0.1f", req, what, act, exp);
    end
  endtask

  function automatic bit in_window(input int v);
    return (v >= 2) && (v <= 3);
  endfunction

  function automatic real absdiff(input real a, input real b);
    return (a > b) ? a - b : b - a;
  endfunction

  bit  mon_on = 1'b0;
  int  owner = -1;
  int  cur_src = 0;
  real cur_rise = 0.0;
  bit  waiting = 1'b0, new_seen = 1'b0;
  int  n_old = 0, gap_base = 0, new_gap = 0;

  always @(posedge clk_o) if (mon_on) begin
    real tr;
    int  src;
    tr = $realtime;
    #0.1;
    src = -1;
    if (clk0_i && rise_t[0] == tr) src = 0;
    else if (clk1_i && rise_t[1] == tr) src = 1;
    chk(src >= 0, "R2", "output rise matches a source rise", real'(src), 0.0);
    cur_src  = (src < 0) ? 0 : src;
    cur_rise = tr;
    if (src >= 0 && src != owner) begin
      if (waiting && src == int'(sel_i)) begin
        owner    = src;
        new_gap  = fall_cnt[src] - gap_base;
        new_seen = 1'b1;
        waiting  = 1'b0;
      end else begin
        chk(1'b0, "R3", "pulse from deselected source", real'(src), real'(owner));
      end
    end
  end

  always @(negedge clk_o) if (mon_on) begin
    real tf;
    tf = $realtime;
    #0.1;
    chk(fall_t[cur_src] == tf, "R2", "output fall matches source fall", tf, fall_t[cur_src]);
    chk(absdiff(tf - cur_rise, real'(rise_hp[cur_src])) < 0.05, "R2",
        "pulse width equals source high phase", tf - cur_rise, real'(rise_hp[cur_src]));
    if (waiting && cur_src == owner && cur_src != int'(sel_i)) begin
      n_old++;
      gap_base = fall_cnt[1-cur_src];
    end
  end

  task automatic begin_switch(input bit s);
    @(negedge tb_clk);
    n_old    = 0;
    new_seen = 1'b0;
    gap_base = fall_cnt[s];
    waiting  = 1'b1;
    sel_i    = s;
  endtask

  task automatic finish_switch(input string gap_req);
    int k = 0;
    while (!new_seen && k < 3000) begin @(posedge tb_clk); k++; end
    chk(new_seen, gap_req, "new source reached output", real'(new_seen), 1.0);
    chk(in_window(n_old), "R4", "old pulses after select change", real'(n_old), 2.0);
    chk(in_window(new_gap), gap_req, "new-clock falls before restart", real'(new_gap), 2.0);
  endtask

  task automatic switch_to(input bit s, input string gap_req);
    begin_switch(s);
    finish_switch(gap_req);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (150000) @(posedge tb_clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    bit s;
    void'($urandom(32'd20240611));
    rst_ni = 1'b0;
    sel_i  = 1'b0;
    // R1: output held low in reset
    for (int i = 0; i < 5; i++) begin
      @(negedge tb_clk);
      chk(clk_o === 1'b0, "R1", "output low during reset", real'(clk_o), 0.0);
    end
    mon_on   = 1'b1;
    owner    = -1;
    n_old    = 0;
    new_seen = 1'b0;
    gap_base = fall_cnt[0];
    waiting  = 1'b1;
    rst_ni   = 1'b1;
    begin
      int k = 0;
      while (!new_seen && k < 3000) begin @(posedge tb_clk); k++; end
    end
    chk(owner == 0, "R1", "first source after reset", real'(owner), 0.0);
    chk(in_window(new_gap), "R1", "falls before first pulse", real'(new_gap), 2.0);

    // R8: equal frequencies, then ten-to-one both ways
    hp = '{7, 7};
    switch_to(1'b1, "R5");
    repeat (20) @(posedge tb_clk);
    hp = '{3, 30};
    switch_to(1'b0, "R8");
    repeat (20) @(posedge tb_clk);
    switch_to(1'b1, "R8");
    repeat (20) @(posedge tb_clk);
    hp = '{30, 3};
    switch_to(1'b0, "R8");
    repeat (20) @(posedge tb_clk);

    // random ratios within 10x
    for (int n = 0; n < 24; n++) begin
      s = ~sel_i;
      hp[s] = $urandom_range(30, 3);
      switch_to(s, "R5");
      repeat ($urandom_range(40, 5)) @(posedge tb_clk);
    end

    // R6: target clock stopped low
    s = ~sel_i;
    run[s] = 1'b0;
    repeat (10) @(posedge tb_clk);
    begin_switch(s);
    repeat (100) @(posedge tb_clk);
    @(negedge tb_clk);
    chk(clk_o === 1'b0, "R6", "output parked low", real'(clk_o), 0.0);
    chk(!new_seen, "R6", "no pulse from dead clock", real'(new_seen), 0.0);
    chk(in_window(n_old), "R6", "old pulses before park", real'(n_old), 2.0);
    run[s] = 1'b1;
    finish_switch("R6");
    repeat (20) @(posedge tb_clk);

    // R7: origin clock stopped low
    s = sel_i;
    run[s] = 1'b0;
    repeat (10) @(posedge tb_clk);
    begin_switch(~s);
    repeat (100) @(posedge tb_clk);
    @(negedge tb_clk);
    chk(clk_o === 1'b0, "R7", "output low with origin dead", real'(clk_o), 0.0);
    chk(n_old == 0 && !new_seen, "R7", "no pulse while origin dead",
        real'(n_old + int'(new_seen)), 0.0);
    run[s] = 1'b1;
    finish_switch("R7");
    repeat (20) @(posedge tb_clk);

    summary();
    $finish;
  end
endmodule